// File: doc/BRIEF.md
# Glitch-Free Gated Clock Output

This block drives an external clock pin from an internal reference clock. In free-running mode the pin carries the reference clock all the time. In receiver-follow mode the pin carries the clock only while a companion receiver is powered. A guard margin keeps the clock running on both sides of each receiver power transition. A force-low control stops the pin completely. Whenever the pin is not clocking, it is held low.

The control inputs are sampled on the rising edge of `refClk`. The resulting gate request is moved into a gate flop on the falling edge. That flop is ANDed with the reference clock, so the gate can only open or close while the clock is low, and the pin never emits a shortened high phase. Before the receiver leaves its off state, the receiver controller raises `wakeReq` early enough to cover the pre-wake margin. After the receiver turns off, an internal down-counter keeps the clock alive for `HOLD_CYCLES` more sampled cycles. Generating the 38.4 kHz or 40 kHz reference is done outside this block, and so is the receiver state machine.

Top module: `clkout_gate_top`

## Requirements
- R1: With `forceLow` and `intermittentEn` both 0 at rising edge k, `clkOut` carries a full high pulse in the `refClk` cycle that starts at edge k+1. The gate changes only during the low phase after edge k.
- R2: With `forceLow`=0, `intermittentEn`=1 and `rxOff`=0 at edge k, `clkOut` pulses in the cycle that starts at edge k+1.
- R3: Let edge k be the first edge at which `rxOff` is sampled 1 after being sampled 0. The gate is then requested at edges k through k+HOLD_CYCLES-1 and dropped at edge k+HOLD_CYCLES, provided `wakeReq` stays 0. Any edge that samples `rxOff`=0 reloads the full margin.
- R4: With `forceLow`=0 and `wakeReq`=1 at edge k, `clkOut` pulses in the cycle that starts at edge k+1, even when `rxOff`=1 and the hold margin has run out.
- R5: `clkOut` is 0 during every low phase of `refClk`. It is also 0 for the whole cycle whenever the gate is closed.
- R6: With `forceLow`=1 at edge k, there is no pulse in the cycle that starts at edge k+1, whatever the values of `intermittentEn`, `rxOff` and `wakeReq`.
- R7: While `rstN` is 0, `clkOut` is 0 and the hold margin is empty. A receiver that is off when reset releases gets no clock until `rxOff` drops or `wakeReq` rises.
- R8: Every high phase of `clkOut` spans the whole high phase of `refClk`. No pulse is shorter than half a reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; also clocks the gating logic |
| rstN | input | 1 | Asynchronous active-low reset |
| intermittentEn | input | 1 | 1 = clock only while the receiver is active (receiver-follow mode) |
| forceLow | input | 1 | 1 = output held low; overrides `intermittentEn` |
| rxOff | input | 1 | 1 = receiver is in its off state |
| wakeReq | input | 1 | Early wake request from the receiver controller; opens the gate ahead of the receiver leaving the off state |
| clkOut | output | 1 | Gated clock pin |

## Verification
A wrong gate request shows up at the pin exactly one cycle after the edge that sampled it: a pulse is missing or an extra one appears. A hold counter with the wrong count shows up as a tail after `rxOff` rises that is too long or too short, by exactly the size of the error. A gate flop clocked on the wrong edge, or bypassed, shows up at once as a high level during the reference low phase or as a pulse whose two halves disagree. For this reason the pin is sampled in the early and late parts of the high phase and in the low phase of every cycle.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

  // Operating mode, derived from the two configuration bits
  typedef enum logic [1:0] {
    GATE_FREE   = 2'd0,
    GATE_RX     = 2'd1,
    GATE_FORCED = 2'd2
  } gateMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdLoad;  // reload the post-off margin counter
    logic holdStep;  // count the margin down by one
    logic gateReq;   // clock wanted in the next cycle
  } gateStrobe_t;

endpackage

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkout_gate_pkg::*;
(
  input  logic        intermittentEn,
  input  logic        forceLow,
  input  logic        rxOff,
  input  logic        wakeReq,
  input  logic        holdActive,
  output gateStrobe_t strobe
);

  gateMode_e mode;
  logic      rxWantsClock;

  always_comb begin
    if (forceLow)            mode = GATE_FORCED;
    else if (intermittentEn) mode = GATE_RX;
    else                     mode = GATE_FREE;
  end

  // The receiver needs a clock while it is active, while an early wake is
  // pending, and while the post-off margin is still running.
  assign rxWantsClock = !rxOff || wakeReq || holdActive;

  always_comb begin
    strobe.holdLoad = !rxOff;
    strobe.holdStep = rxOff && holdActive;
    unique case (mode)
      GATE_FREE:   strobe.gateReq = 1'b1;
      GATE_RX:     strobe.gateReq = rxWantsClock;
      default:     strobe.gateReq = 1'b0;
    endcase
  end

endmodule

// File: rtl/clkout_gate_dpath.sv
module clkout_gate_dpath
  import clkout_gate_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic        refClk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        holdActive,
  output logic        gateEn,
  output logic        clkOut
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;
  logic             reqQ;
  logic             gateQ;

  // Post-off margin counter, kept full while the receiver is active
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobe.holdLoad) holdCnt <= HOLD_LOAD;
    else if (strobe.holdStep) holdCnt <= holdCnt - 1'b1;
  end

  assign holdActive = (holdCnt != '0);

  // Gate request captured on the rising edge
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= strobe.gateReq;
  end

  // Gate moves only on the falling edge, so it changes while the clock is low
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= reqQ;
  end

  assign gateEn = gateQ;
  assign clkOut = refClk & gateQ;

endmodule

// File: rtl/clkout_gate_top.sv
module clkout_gate_top
  import clkout_gate_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic refClk,
  input  logic rstN,
  input  logic intermittentEn,
  input  logic forceLow,
  input  logic rxOff,
  input  logic wakeReq,
  output logic clkOut
);

  gateStrobe_t strobe;
  logic        holdActive;
  logic        gateEn;

  clkout_gate_ctrl u_ctrl (
    .intermittentEn (intermittentEn),
    .forceLow       (forceLow),
    .rxOff          (rxOff),
    .wakeReq        (wakeReq),
    .holdActive     (holdActive),
    .strobe         (strobe)
  );

  clkout_gate_dpath #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dpath (
    .refClk     (refClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .holdActive (holdActive),
    .gateEn     (gateEn),
    .clkOut     (clkOut)
  );

endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk (
  input logic refClk,
  input logic rstN,
  input logic intermittentEn,
  input logic forceLow,
  input logic rxOff,
  input logic wakeReq,
  input logic gateEn
);

  AST_FREE_RUN: assert property (@(posedge refClk) disable iff (!rstN)
    (!forceLow && !intermittentEn) |=> gateEn); // R1

  AST_RX_ACTIVE: assert property (@(posedge refClk) disable iff (!rstN)
    (!forceLow && !rxOff) |=> gateEn); // R2

  AST_HOLD_START: assert property (@(posedge refClk) disable iff (!rstN)
    (!forceLow && $rose(rxOff)) |=> gateEn); // R3

  AST_WAKE_OPEN: assert property (@(posedge refClk) disable iff (!rstN)
    (!forceLow && wakeReq) |=> gateEn); // R4

  AST_FORCE_SHUT: assert property (@(posedge refClk) disable iff (!rstN)
    forceLow |=> !gateEn); // R6

endmodule

bind clkout_gate_top clkout_gate_chk u_chk (
  .refClk         (refClk),
  .rstN           (rstN),
  .intermittentEn (intermittentEn),
  .forceLow       (forceLow),
  .rxOff          (rxOff),
  .wakeReq        (wakeReq),
  .gateEn         (gateEn)
);

// File: tb/test_clkout_gate_top.sv
`timescale 1ns/1ps
module test_clkout_gate_top;

  localparam int HOLD = 4;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } expItem_t;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic intermittentEn = 1'b0;
  logic forceLow = 1'b0;
  logic rxOff = 1'b0;
  logic wakeReq = 1'b0;
  logic clkOut;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int runLen = HOLD + 1;
  expItem_t expQ[$];

  clkout_gate_top #(.HOLD_CYCLES(HOLD)) i_clkout_gate_top (
    .refClk(refClk), .rstN(rstN), .intermittentEn(intermittentEn),
    .forceLow(forceLow), .rxOff(rxOff), .wakeReq(wakeReq), .clkOut(clkOut)
  );

  always #4 refClk = ~refClk;

  task automatic check(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cycle, act, exp);
    end
  endtask

  // Driver: set inputs in the high phase of the current cycle and push the
  // pulse expected two cycles later (sampled at the next edge, shown after it).
  task automatic step(input bit inter, input bit force_, input bit off,
                      input bit wake, input string tag);
    expItem_t it;
    bit want;
    @(posedge refClk);
    #2;
    intermittentEn = inter;
    forceLow = force_;
    rxOff = off;
    wakeReq = wake;
    if (off) runLen = (runLen > HOLD) ? HOLD + 1 : runLen + 1;
    else     runLen = 0;
    want = !force_ && (!inter || !off || wake || (runLen <= HOLD));
    it.cyc = cycle + 2;
    it.val = want;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: early/late high phase and low phase of every cycle
  initial begin
    forever begin
      bit hiA, hiB;
      @(posedge refClk);
      cycle++;
      #1 hiA = clkOut;
      #2 hiB = clkOut;
      check("R8 high phase whole", hiB, hiA);
      if (expQ.size() > 0 && expQ[0].cyc == cycle) begin
        expItem_t it = expQ.pop_front();
        check(it.tag, hiA, it.val);
      end
      #2 check("R5 low phase", clkOut, 1'b0);
    end
  end

  initial begin
    fork
      begin
        // reset, receiver off in follow mode: no clock after release
        intermittentEn = 1'b1;
        rxOff = 1'b1;
        repeat (3) begin
          @(posedge refClk);
          #2 check("R7 reset low", clkOut, 1'b0);
        end
        rstN = 1'b1;
        repeat (4) step(1, 0, 1, 0, "R7 idle after reset");
        repeat (8) step(0, 0, 0, 0, "R1 free run");
        repeat (6) step(1, 0, 0, 0, "R2 receiver active");
        repeat (10) step(1, 0, 1, 0, "R3 post-off margin");
        repeat (2) step(1, 0, 0, 0, "R2 receiver back");
        repeat (2) step(1, 0, 1, 0, "R3 short off");
        step(1, 0, 0, 0, "R3 reload");
        repeat (8) step(1, 0, 1, 0, "R3 margin after reload");
        repeat (4) step(1, 0, 1, 1, "R4 early wake");
        repeat (3) step(1, 0, 0, 0, "R4 after wake");
        repeat (4) step(0, 1, 0, 0, "R6 force in free mode");
        repeat (4) step(1, 1, 0, 1, "R6 force in follow mode");
        repeat (5) step(0, 0, 1, 0, "R1 free run with receiver off");
        repeat (3) step(0, 0, 1, 0, "R1 tail");
        repeat (4) @(posedge refClk);
      end
      begin
        repeat (5000) @(posedge refClk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule